// File: doc/BRIEF.md
# Effective Address Generator

This unit forms the 24-bit bus address for an 8/16-bit processor core. Each address is a bank byte above a 16-bit offset. The core presents an addressing-mode code with the register values it holds: direct register, direct page offset, 16-bit base, X and Y index, stack pointer, program counter and program bank. One clock later the unit returns a registered address with a one-cycle valid pulse.

The two indirect modes take two steps. First the unit issues the address of a 16-bit pointer in bank zero, flagged as a pointer read, and waits. When the core returns the pointer word, the unit issues the final operand address on the next cycle. The pre-indexed form adds X before the pointer read. The post-indexed form adds Y, captured when the request was accepted, to the pointer after it is read, and that sum may carry into the bank byte.

A narrow-index flag limits every index contribution to its low byte.

Top module: `eag_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `addrValid`, `addrIsPtr` and `busy` are 0.
- R2: Mode 0 (direct): when a request is accepted, the next cycle shows bank 0x00 and offset (direct register + zero-extended direct offset) mod 2^16. Any carry out of bit 15 is dropped.
- R3: Modes 1 and 2 (direct indexed by X, by Y): bank 0x00 and offset (direct register + direct offset + index) mod 2^16.
- R4: Modes 3 and 4 (absolute indexed by X, by Y): the address is the 24-bit sum of {0x00, base} and the index. A carry out of the offset increments the bank byte.
- R5: When `idxNarrow` is 1, every index contribution uses only bits 7:0 of X or Y, with the upper byte taken as zero.
- R6: Mode 5 (stack): bank 0x00 and offset equal to the stack pointer.
- R7: Mode 6 (program fetch): bank equals the program bank input and offset equals the program counter.
- R8: Mode 7 (pre-indexed indirect): the next cycle shows `addrIsPtr`=1 at bank 0x00, offset (direct register + direct offset + X) mod 2^16. One cycle after `ptrValid`, the unit shows `addrIsPtr`=0 at {0x00, ptrData}.
- R9: Mode 8 (post-indexed indirect): the pointer address is bank 0x00, offset (direct register + direct offset) mod 2^16. The final address is the 24-bit sum of {0x00, ptrData} and the Y value held at acceptance, with the carry going into the bank.
- R10: From the cycle after an indirect request is accepted until the cycle after `ptrValid`, `busy` is 1. During that time requests are ignored and no address is shown except the final one.
- R11: When not busy, `ptrValid` has no effect, and mode codes 9 to 15 produce no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, accepted when not busy |
| reqMode | input | 4 | Addressing-mode code (0..8) |
| idxNarrow | input | 1 | Index width flag: 1 = 8-bit index |
| dpOffset | input | 8 | Direct page offset from the instruction |
| baseAddr | input | 16 | Absolute base address |
| idxX | input | 16 | X index register |
| idxY | input | 16 | Y index register |
| dirReg | input | 16 | Direct register |
| stackPtr | input | 16 | Stack pointer |
| progCnt | input | 16 | Program counter |
| progBank | input | 8 | Program bank register |
| ptrValid | input | 1 | Pointer word is present on ptrData |
| ptrData | input | 16 | Pointer word read at the pointer address |
| addrValid | output | 1 | One-cycle pulse, address valid |
| addrBank | output | 8 | Bank byte of the address |
| addrOffset | output | 16 | 16-bit offset of the address |
| addrIsPtr | output | 1 | Address is an indirect pointer read |
| busy | output | 1 | Waiting for a pointer word |

## Verification
Two events can meet in one cycle. A new request can arrive in the same cycle that `ptrValid` completes an indirect access. A pointer word can also appear alongside a request while the unit is idle. The bench provokes both with directed sequences, and the random phase keeps `reqValid` and `ptrValid` toggling on their own. A behavioural model decides each time which event wins: the request is dropped while waiting, and the pointer is dropped while idle. The model then predicts the single pulse that must follow, and the bench compares it on every clock.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int OFS_W  = 16;
  localparam int BANK_W = 8;
  localparam int DPO_W  = 8;
  localparam int NARROW_W = 8;
  localparam int MODE_W = 4;
  localparam int FULL_W = OFS_W + BANK_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_DIRECT   = 4'd0,
    MODE_DIR_X    = 4'd1,
    MODE_DIR_Y    = 4'd2,
    MODE_ABS_X    = 4'd3,
    MODE_ABS_Y    = 4'd4,
    MODE_STACK    = 4'd5,
    MODE_PROG     = 4'd6,
    MODE_IND_PRE  = 4'd7,
    MODE_IND_POST = 4'd8
  } eagMode_e;

  typedef struct packed {
    logic emitImm;
    logic emitPtr;
    logic emitFinal;
  } eagStrobe_t;
endpackage

// File: rtl/eag_control.sv
module eag_control
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [MODE_W-1:0] reqMode,
  input  logic              ptrValid,
  output eagStrobe_t        stb,
  output logic              busy
);
  typedef enum logic {ST_IDLE, ST_WAIT} ctrlState_e;
  ctrlState_e stateQ;

  logic reqImm, reqInd;

  always_comb begin
    reqImm = (reqMode <= MODE_W'(MODE_PROG));
    reqInd = (reqMode == MODE_W'(MODE_IND_PRE)) || (reqMode == MODE_W'(MODE_IND_POST));
    stb.emitImm   = (stateQ == ST_IDLE) && reqValid && reqImm;
    stb.emitPtr   = (stateQ == ST_IDLE) && reqValid && reqInd;
    stb.emitFinal = (stateQ == ST_WAIT) && ptrValid;
    busy          = (stateQ == ST_WAIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             stateQ <= ST_IDLE;
    else if (stb.emitPtr)  stateQ <= ST_WAIT;
    else if (stb.emitFinal) stateQ <= ST_IDLE;
  end

  assert_single_emit_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.emitImm, stb.emitPtr, stb.emitFinal}));
  assert_wait_after_ptr_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.emitPtr |=> busy);
  assert_release_after_final_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.emitFinal |=> !busy);
endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  eagStrobe_t        stb,
  input  logic [MODE_W-1:0] mode,
  input  logic              idxNarrow,
  input  logic [DPO_W-1:0]  dpOffset,
  input  logic [OFS_W-1:0]  baseAddr,
  input  logic [OFS_W-1:0]  idxX,
  input  logic [OFS_W-1:0]  idxY,
  input  logic [OFS_W-1:0]  dirReg,
  input  logic [OFS_W-1:0]  stackPtr,
  input  logic [OFS_W-1:0]  progCnt,
  input  logic [BANK_W-1:0] progBank,
  input  logic [OFS_W-1:0]  ptrData,
  output logic              addrValid,
  output logic [BANK_W-1:0] addrBank,
  output logic [OFS_W-1:0]  addrOffset,
  output logic              addrIsPtr
);
  localparam logic [BANK_W-1:0] ZERO_BANK = '0;

  function automatic logic [OFS_W-1:0] sizeIdx(input logic [OFS_W-1:0] v, input logic narrow);
    return narrow ? {{(OFS_W-NARROW_W){1'b0}}, v[NARROW_W-1:0]} : v;
  endfunction

  logic [OFS_W-1:0]  xEff, yEff, dpBase, dpIdxX, dpIdxY;
  logic [FULL_W-1:0] immAddr, ptrAddr, finalAddr, nextAddr;
  logic              postQ;
  logic [OFS_W-1:0]  yHoldQ;

  always_comb begin
    xEff   = sizeIdx(idxX, idxNarrow);
    yEff   = sizeIdx(idxY, idxNarrow);
    dpBase = dirReg + {{(OFS_W-DPO_W){1'b0}}, dpOffset};
    dpIdxX = dpBase + xEff;
    dpIdxY = dpBase + yEff;
    case (mode)
      MODE_W'(MODE_DIR_X): immAddr = {ZERO_BANK, dpIdxX};
      MODE_W'(MODE_DIR_Y): immAddr = {ZERO_BANK, dpIdxY};
      MODE_W'(MODE_ABS_X): immAddr = {ZERO_BANK, baseAddr} + {ZERO_BANK, xEff};
      MODE_W'(MODE_ABS_Y): immAddr = {ZERO_BANK, baseAddr} + {ZERO_BANK, yEff};
      MODE_W'(MODE_STACK): immAddr = {ZERO_BANK, stackPtr};
      MODE_W'(MODE_PROG):  immAddr = {progBank, progCnt};
      default:             immAddr = {ZERO_BANK, dpBase};
    endcase
    ptrAddr   = (mode == MODE_W'(MODE_IND_PRE)) ? {ZERO_BANK, dpIdxX} : {ZERO_BANK, dpBase};
    finalAddr = postQ ? ({ZERO_BANK, ptrData} + {ZERO_BANK, yHoldQ}) : {ZERO_BANK, ptrData};
    if (stb.emitFinal)    nextAddr = finalAddr;
    else if (stb.emitPtr) nextAddr = ptrAddr;
    else                  nextAddr = immAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrValid  <= 1'b0;
      addrIsPtr  <= 1'b0;
      addrBank   <= '0;
      addrOffset <= '0;
      postQ      <= 1'b0;
      yHoldQ     <= '0;
    end else begin
      addrValid <= stb.emitImm | stb.emitPtr | stb.emitFinal;
      addrIsPtr <= stb.emitPtr;
      if (stb.emitImm | stb.emitPtr | stb.emitFinal)
        {addrBank, addrOffset} <= nextAddr;
      if (stb.emitPtr) begin
        postQ  <= (mode == MODE_W'(MODE_IND_POST));
        yHoldQ <= yEff;
      end
    end
  end

  assert_ptr_in_bank_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && addrIsPtr) |-> (addrBank == '0));
  assert_stack_bank_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emitImm && mode == MODE_W'(MODE_STACK)) |=>
      (addrValid && addrBank == '0 && addrOffset == $past(stackPtr)));
  assert_prog_fetch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emitImm && mode == MODE_W'(MODE_PROG)) |=>
      (addrValid && addrBank == $past(progBank) && addrOffset == $past(progCnt)));
  assert_direct_bank_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emitImm && mode == MODE_W'(MODE_DIRECT)) |=> (addrValid && addrBank == '0));
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [MODE_W-1:0] reqMode,
  input  logic              idxNarrow,
  input  logic [DPO_W-1:0]  dpOffset,
  input  logic [OFS_W-1:0]  baseAddr,
  input  logic [OFS_W-1:0]  idxX,
  input  logic [OFS_W-1:0]  idxY,
  input  logic [OFS_W-1:0]  dirReg,
  input  logic [OFS_W-1:0]  stackPtr,
  input  logic [OFS_W-1:0]  progCnt,
  input  logic [BANK_W-1:0] progBank,
  input  logic              ptrValid,
  input  logic [OFS_W-1:0]  ptrData,
  output logic              addrValid,
  output logic [BANK_W-1:0] addrBank,
  output logic [OFS_W-1:0]  addrOffset,
  output logic              addrIsPtr,
  output logic              busy
);
  eagStrobe_t stb;

  eag_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .ptrValid(ptrValid), .stb(stb), .busy(busy)
  );

  eag_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mode(reqMode), .idxNarrow(idxNarrow),
    .dpOffset(dpOffset), .baseAddr(baseAddr), .idxX(idxX), .idxY(idxY),
    .dirReg(dirReg), .stackPtr(stackPtr), .progCnt(progCnt), .progBank(progBank),
    .ptrData(ptrData), .addrValid(addrValid), .addrBank(addrBank),
    .addrOffset(addrOffset), .addrIsPtr(addrIsPtr)
  );

  assert_busy_blocks_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ptrValid) |=> !addrValid);
  assert_bad_mode_silent_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqMode > MODE_W'(MODE_IND_POST)) |=> !addrValid);
  assert_idle_ptr_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !reqValid) |=> !addrValid);
endmodule

// File: tb/sim_eag_top.sv
module sim_eag_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  reqMode = '0;
  logic        idxNarrow = 1'b0;
  logic [7:0]  dpOffset = '0;
  logic [15:0] baseAddr = '0, idxX = '0, idxY = '0, dirReg = '0;
  logic [15:0] stackPtr = '0, progCnt = '0, ptrData = '0;
  logic [7:0]  progBank = '0;
  logic        ptrValid = 1'b0;
  logic        addrValid, addrIsPtr, busy;
  logic [7:0]  addrBank;
  logic [15:0] addrOffset;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  eag_top u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .idxNarrow(idxNarrow), .dpOffset(dpOffset), .baseAddr(baseAddr),
    .idxX(idxX), .idxY(idxY), .dirReg(dirReg), .stackPtr(stackPtr),
    .progCnt(progCnt), .progBank(progBank), .ptrValid(ptrValid),
    .ptrData(ptrData), .addrValid(addrValid), .addrBank(addrBank),
    .addrOffset(addrOffset), .addrIsPtr(addrIsPtr), .busy(busy)
  );

  // Behavioural reference model, updated on each rising edge.
  bit       expValid, expPtr, mWait, mPost;
  int       expAddr;
  int       mY;
  string    expTag = "R1";

  function automatic int nidx(input int v);
    return idxNarrow ? (v & 'hFF) : (v & 'hFFFF);
  endfunction

  always @(posedge clk) begin
    int d;
    if (!rstN) begin
      expValid = 0; expPtr = 0; mWait = 0; mPost = 0; mY = 0; expTag = "R1";
    end else begin
      expValid = 0; expPtr = 0;
      d = int'(dirReg) + int'(dpOffset);
      if (mWait) begin
        expTag = "R10";
        if (ptrValid) begin
          expValid = 1; mWait = 0;
          expAddr = mPost ? (int'(ptrData) + mY) : int'(ptrData);
          expTag = mPost ? "R9" : "R8";
        end
      end else if (reqValid) begin
        expValid = 1;
        case (reqMode)
          4'd0: begin expAddr = d & 'hFFFF; expTag = "R2"; end
          4'd1: begin expAddr = (d + nidx(idxX)) & 'hFFFF; expTag = idxNarrow ? "R5" : "R3"; end
          4'd2: begin expAddr = (d + nidx(idxY)) & 'hFFFF; expTag = idxNarrow ? "R5" : "R3"; end
          4'd3: begin expAddr = int'(baseAddr) + nidx(idxX); expTag = idxNarrow ? "R5" : "R4"; end
          4'd4: begin expAddr = int'(baseAddr) + nidx(idxY); expTag = idxNarrow ? "R5" : "R4"; end
          4'd5: begin expAddr = int'(stackPtr); expTag = "R6"; end
          4'd6: begin expAddr = (int'(progBank) << 16) | int'(progCnt); expTag = "R7"; end
          4'd7: begin expAddr = (d + nidx(idxX)) & 'hFFFF; expPtr = 1; mWait = 1; mPost = 0; expTag = "R8"; end
          4'd8: begin expAddr = d & 'hFFFF; expPtr = 1; mWait = 1; mPost = 1; mY = nidx(idxY); expTag = "R9"; end
          default: begin expValid = 0; expTag = "R11"; end
        endcase
      end else begin
        expTag = "R11";
      end
    end
  end

  always @(negedge clk) begin
    int got;
    if (!done) begin
      checks++;
      got = (int'(addrBank) << 16) | int'(addrOffset);
      if (addrValid !== expValid || addrIsPtr !== expPtr || busy !== mWait ||
          (expValid && got !== expAddr)) begin
        errors++;
        $display("FAIL %s: valid/ptr/busy/addr actual %0b/%0b/%0b/%06h expected %0b/%0b/%0b/%06h",
                 expTag, addrValid, addrIsPtr, busy, got, expValid, expPtr, mWait,
                 expValid ? expAddr : got);
      end
    end
  end

  task automatic step(); @(negedge clk); endtask

  task automatic req(input logic [3:0] m);
    reqValid = 1; reqMode = m; step(); reqValid = 0;
  endtask

  initial begin
    int seed = 11;
    repeat (3) step();
    rstN = 1;                  // R1: reset state checked every cycle above
    step();
    // R2: direct with carry dropped
    dirReg = 16'hFFF0; dpOffset = 8'h20; req(4'd0); step();
    // R3 / R5: direct indexed, wide then narrow
    idxX = 16'h12FF; req(4'd1); step();
    idxNarrow = 1; req(4'd1); step();
    idxY = 16'hAB01; req(4'd2); step(); idxNarrow = 0;
    // R4: absolute indexed carrying into bank
    baseAddr = 16'hFFF0; idxY = 16'h0020; req(4'd4); step();
    idxX = 16'h0001; req(4'd3); step();
    // R6, R7
    stackPtr = 16'h01FD; req(4'd5);
    progBank = 8'h7E; progCnt = 16'h8000; req(4'd6); step();
    // R8 with R10: requests during wait are dropped
    dirReg = 16'h0100; dpOffset = 8'h10; idxX = 16'h0004; req(4'd7);
    reqValid = 1; reqMode = 4'd5; step(); step(); reqValid = 0;
    ptrData = 16'h3456; ptrValid = 1; reqValid = 1; reqMode = 4'd6; step();
    ptrValid = 0; reqValid = 0; step();
    // R9: post-indexed with Y changed after acceptance and carry into bank
    idxY = 16'hFFFF; req(4'd8); idxY = 16'h0000; step();
    ptrData = 16'h0002; ptrValid = 1; step(); ptrValid = 0; step();
    // R11: pointer while idle, and undefined modes
    ptrValid = 1; step(); ptrValid = 0;
    req(4'd9); req(4'd15); step();
    ptrValid = 1; req(4'd12); ptrValid = 0; step();
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      reqValid  = ($urandom(seed + i) % 2) == 0;
      reqMode   = 4'($urandom % 16);
      idxNarrow = ($urandom % 4) == 0;
      dpOffset  = 8'($urandom);
      baseAddr  = 16'($urandom); idxX = 16'($urandom); idxY = 16'($urandom);
      dirReg    = 16'($urandom); stackPtr = 16'($urandom); progCnt = 16'($urandom);
      progBank  = 8'($urandom); ptrData = 16'($urandom);
      ptrValid  = ($urandom % 3) == 0;
      step();
    end
    reqValid = 0; ptrValid = 0;
    step(); step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule